// File: doc/BRIEF.md
# AXI4 Write-Path Burst Buffer with Packet Release

This block sits on the write side of an AXI4 slave-facing port. It takes the address (AW) and data (W) channels from a master and drives them toward a slave. It passes the write response (B) channel through unchanged. A build-time mode picks one of three variants. The first is a plain combinational wire-through. The second places a shallow FIFO on the data channel only. The third uses a deep data FIFO together with a shallow address FIFO, and withholds each burst's address until all of that burst's beats are stored.

In the third variant, called packet mode, the outgoing data channel cannot stall inside a burst for lack of data. Once the first beat of a burst leaves, the rest of that burst is already buffered. Data beats of a burst are also held back until that burst's address has been accepted downstream, so addresses and data leave in a matching order. Masters may send data ahead of the address, or the address ahead of the data.

Top module: `axi_wr_pkt_fifo`

## Requirements
- R1: With MODE = WPF_WIRE (0), every outgoing AW, W and B signal equals its incoming counterpart in the same cycle, including the ready signals flowing back.
- R2: With MODE = WPF_DFIFO (1), the AW channel is wired straight through. W beats go through a FIFO of W_DEPTH entries. An accepted beat appears on m_wvalid/m_wdata in the cycle after its handshake, and s_wready is low while W_DEPTH beats are held.
- R3: Every buffering mode delivers the beats in the order accepted. Each beat's WDATA, WSTRB and WLAST are kept together unchanged. In packet mode, addresses leave in the order accepted.
- R4: With MODE = WPF_PACKET (2), m_awvalid is high only while a burst whose last beat (WLAST = 1) has been stored still lacks its address issue. An address that arrives before its data is not offered until that burst's last beat is stored.
- R5: In packet mode, m_wvalid stays low for a burst until that burst's address handshake has completed on the outgoing AW channel.
- R6: In packet mode, after a non-last beat handshake on the outgoing W channel, m_wvalid is high in every following cycle until the beat with WLAST = 1 is accepted. A beat offered and not accepted stays on the outputs unchanged.
- R7: In packet mode, s_wready is low exactly while P_DEPTH beats are held. s_awready is low exactly while A_DEPTH addresses are held.
- R8: In every mode, s_bvalid, s_bresp and m_bready are combinational copies of m_bvalid, m_bresp and s_bready.
- R9: After a synchronous active-high reset, both FIFOs are empty, the burst counters are clear, all buffered output valids are low, and s_awready and s_wready are high.
- R10: In packet mode, a burst of exactly P_DEPTH beats is accepted in full and released. Any accepted AWLEN + 1 greater than P_DEPTH is a protocol violation that the checker flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Incoming address valid |
| s_awready | output | 1 | Incoming address ready |
| s_awaddr | input | ADDR_W | Incoming burst address |
| s_awlen | input | 8 | Incoming burst length minus one |
| s_awsize | input | 3 | Incoming beat size code |
| s_awburst | input | 2 | Incoming burst type |
| s_wvalid | input | 1 | Incoming data valid |
| s_wready | output | 1 | Incoming data ready |
| s_wdata | input | DATA_W | Incoming beat data |
| s_wstrb | input | DATA_W/8 | Incoming byte enables |
| s_wlast | input | 1 | Incoming last beat flag |
| s_bvalid | output | 1 | Response valid toward master |
| s_bready | input | 1 | Response ready from master |
| s_bresp | output | 2 | Response code toward master |
| m_awvalid | output | 1 | Outgoing address valid |
| m_awready | input | 1 | Outgoing address ready |
| m_awaddr | output | ADDR_W | Outgoing burst address |
| m_awlen | output | 8 | Outgoing burst length minus one |
| m_awsize | output | 3 | Outgoing beat size code |
| m_awburst | output | 2 | Outgoing burst type |
| m_wvalid | output | 1 | Outgoing data valid |
| m_wready | input | 1 | Outgoing data ready |
| m_wdata | output | DATA_W | Outgoing beat data |
| m_wstrb | output | DATA_W/8 | Outgoing byte enables |
| m_wlast | output | 1 | Outgoing last beat flag |
| m_bvalid | input | 1 | Response valid from slave |
| m_bready | output | 1 | Response ready toward slave |
| m_bresp | input | 2 | Response code from slave |

## Verification
The bench builds three copies side by side, one per mode. All three use W_DEPTH = 4, P_DEPTH = 8 and A_DEPTH = 4, so both FIFOs can be filled to the brim within a few dozen cycles. A burst of AWLEN = 7 exactly fills the packet data buffer, which makes the largest legal burst and the full-flag stall reachable. The shallow address depth lets four queued addresses block s_awready while none of them can be released. The combinational copy is probed while reset is held, the data-only copy for latency and fill, and the packet copy for the release order with data-first and address-first arrival.

// File: rtl/axi_wpf_pkg.sv
package axi_wpf_pkg;

    localparam int AXI_LEN_W   = 8;
    localparam int AXI_SIZE_W  = 3;
    localparam int AXI_BURST_W = 2;
    localparam int AXI_RESP_W  = 2;

    typedef enum int {
        WPF_WIRE   = 0,
        WPF_DFIFO  = 1,
        WPF_PACKET = 2
    } wpf_mode_e;

    function automatic int beats_of(input logic [AXI_LEN_W-1:0] len);
        return int'(len) + 1;
    endfunction

    function automatic bit burst_fits(input logic [AXI_LEN_W-1:0] len, input int depth);
        return beats_of(len) <= depth;
    endfunction

endpackage

// File: rtl/axi_wpf_fifo.sv
module axi_wpf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt, cnt_nxt;
    logic             full_q, empty_q, do_push, do_pop;

    assign do_push = push & ~full_q;
    assign do_pop  = pop & ~empty_q;
    assign cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            rp      <= '0;
            cnt     <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt     <= cnt_nxt;
            full_q  <= (cnt_nxt == CW'(DEPTH));
            empty_q <= (cnt_nxt == '0);
        end
    end

    assign dout  = mem[rp];
    assign full  = full_q;
    assign empty = empty_q;
endmodule

// File: rtl/axi_wpf_release.sv
module axi_wpf_release #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_stored,
    input  logic aw_taken,
    input  logic burst_sent,
    input  logic aw_pending,
    input  logic w_pending,
    output logic aw_go,
    output logic w_go
);
    logic [CNT_W-1:0] whole_cnt;
    logic [CNT_W-1:0] open_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            whole_cnt <= '0;
            open_cnt  <= '0;
        end else begin
            whole_cnt <= whole_cnt + CNT_W'(burst_stored) - CNT_W'(aw_taken);
            open_cnt  <= open_cnt + CNT_W'(aw_taken) - CNT_W'(burst_sent);
        end
    end

    assign aw_go = aw_pending & (whole_cnt != '0);
    assign w_go  = w_pending & (open_cnt != '0);
endmodule

// File: rtl/axi_wr_pkt_fifo.sv
module axi_wr_pkt_fifo
    import axi_wpf_pkg::*;
#(
    parameter wpf_mode_e MODE    = WPF_PACKET,
    parameter int        ADDR_W  = 32,
    parameter int        DATA_W  = 32,
    parameter int        W_DEPTH = 32,
    parameter int        P_DEPTH = 512,
    parameter int        A_DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s_awvalid,
    output logic                   s_awready,
    input  logic [ADDR_W-1:0]      s_awaddr,
    input  logic [AXI_LEN_W-1:0]   s_awlen,
    input  logic [AXI_SIZE_W-1:0]  s_awsize,
    input  logic [AXI_BURST_W-1:0] s_awburst,
    input  logic                   s_wvalid,
    output logic                   s_wready,
    input  logic [DATA_W-1:0]      s_wdata,
    input  logic [DATA_W/8-1:0]    s_wstrb,
    input  logic                   s_wlast,
    output logic                   s_bvalid,
    input  logic                   s_bready,
    output logic [AXI_RESP_W-1:0]  s_bresp,
    output logic                   m_awvalid,
    input  logic                   m_awready,
    output logic [ADDR_W-1:0]      m_awaddr,
    output logic [AXI_LEN_W-1:0]   m_awlen,
    output logic [AXI_SIZE_W-1:0]  m_awsize,
    output logic [AXI_BURST_W-1:0] m_awburst,
    output logic                   m_wvalid,
    input  logic                   m_wready,
    output logic [DATA_W-1:0]      m_wdata,
    output logic [DATA_W/8-1:0]    m_wstrb,
    output logic                   m_wlast,
    input  logic                   m_bvalid,
    output logic                   m_bready,
    input  logic [AXI_RESP_W-1:0]  m_bresp
);
    localparam int STRB_W = DATA_W / 8;
    localparam int CNT_W  = $clog2(P_DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0]      addr;
        logic [AXI_LEN_W-1:0]   len;
        logic [AXI_SIZE_W-1:0]  size;
        logic [AXI_BURST_W-1:0] burst;
    } aw_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              last;
    } w_t;

    localparam int AW_BITS = $bits(aw_t);
    localparam int W_BITS  = $bits(w_t);

    assign s_bvalid = m_bvalid;
    assign s_bresp  = m_bresp;
    assign m_bready = s_bready;

    generate
        if (MODE == WPF_WIRE) begin : g_wire
            assign m_awvalid = s_awvalid;
            assign s_awready = m_awready;
            assign m_awaddr  = s_awaddr;
            assign m_awlen   = s_awlen;
            assign m_awsize  = s_awsize;
            assign m_awburst = s_awburst;
            assign m_wvalid  = s_wvalid;
            assign s_wready  = m_wready;
            assign m_wdata   = s_wdata;
            assign m_wstrb   = s_wstrb;
            assign m_wlast   = s_wlast;
        end else begin : g_buf
            w_t   w_in, w_out;
            logic d_full, d_empty;
            logic w_pop;

            assign w_in     = '{data: s_wdata, strb: s_wstrb, last: s_wlast};
            assign s_wready = ~d_full;
            assign m_wdata  = w_out.data;
            assign m_wstrb  = w_out.strb;
            assign m_wlast  = w_out.last;
            assign w_pop    = m_wvalid & m_wready;

            if (MODE == WPF_DFIFO) begin : g_dfifo
                assign m_awvalid = s_awvalid;
                assign s_awready = m_awready;
                assign m_awaddr  = s_awaddr;
                assign m_awlen   = s_awlen;
                assign m_awsize  = s_awsize;
                assign m_awburst = s_awburst;
                assign m_wvalid  = ~d_empty;

                axi_wpf_fifo #(.WIDTH(W_BITS), .DEPTH(W_DEPTH)) u_wq (
                    .clk(clk), .rst(rst),
                    .push(s_wvalid), .din(w_in), .full(d_full),
                    .pop(w_pop), .dout(w_out), .empty(d_empty)
                );
            end else begin : g_packet
                aw_t  aw_in, aw_out;
                logic a_full, a_empty;
                logic aw_taken, burst_stored, burst_sent;

                assign aw_in = '{addr: s_awaddr, len: s_awlen,
                                 size: s_awsize, burst: s_awburst};
                assign s_awready    = ~a_full;
                assign m_awaddr     = aw_out.addr;
                assign m_awlen      = aw_out.len;
                assign m_awsize     = aw_out.size;
                assign m_awburst    = aw_out.burst;
                assign aw_taken     = m_awvalid & m_awready;
                assign burst_stored = s_wvalid & s_wready & s_wlast;
                assign burst_sent   = w_pop & w_out.last;

                axi_wpf_fifo #(.WIDTH(AW_BITS), .DEPTH(A_DEPTH)) u_awq (
                    .clk(clk), .rst(rst),
                    .push(s_awvalid), .din(aw_in), .full(a_full),
                    .pop(aw_taken), .dout(aw_out), .empty(a_empty)
                );

                axi_wpf_fifo #(.WIDTH(W_BITS), .DEPTH(P_DEPTH)) u_wq (
                    .clk(clk), .rst(rst),
                    .push(s_wvalid), .din(w_in), .full(d_full),
                    .pop(w_pop), .dout(w_out), .empty(d_empty)
                );

                axi_wpf_release #(.CNT_W(CNT_W)) u_rel (
                    .clk(clk), .rst(rst),
                    .burst_stored(burst_stored), .aw_taken(aw_taken),
                    .burst_sent(burst_sent),
                    .aw_pending(~a_empty), .w_pending(~d_empty),
                    .aw_go(m_awvalid), .w_go(m_wvalid)
                );
            end
        end
    endgenerate
endmodule

// File: rtl/axi_wr_pkt_fifo_chk.sv
module axi_wr_pkt_fifo_chk
    import axi_wpf_pkg::*;
#(
    parameter wpf_mode_e MODE    = WPF_PACKET,
    parameter int        ADDR_W  = 32,
    parameter int        DATA_W  = 32,
    parameter int        W_DEPTH = 32,
    parameter int        P_DEPTH = 512,
    parameter int        A_DEPTH = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 s_awvalid,
    input logic                 s_awready,
    input logic [AXI_LEN_W-1:0] s_awlen,
    input logic                 s_wvalid,
    input logic                 s_wready,
    input logic                 s_wlast,
    input logic                 m_awvalid,
    input logic                 m_awready,
    input logic [ADDR_W-1:0]    m_awaddr,
    input logic                 m_wvalid,
    input logic                 m_wready,
    input logic                 m_wlast,
    input logic [DATA_W-1:0]    m_wdata
);
    localparam int D_EFF = (MODE == WPF_DFIFO) ? W_DEPTH : P_DEPTH;
    localparam int OW    = $clog2(D_EFF + 1) + 1;
    localparam int AOW   = $clog2(A_DEPTH + 1) + 1;

    logic [OW-1:0]  occ, stored, open_b;
    logic [AOW-1:0] aocc;
    logic s_w_hs, m_w_hs, s_aw_hs, m_aw_hs;

    assign s_w_hs  = s_wvalid & s_wready;
    assign m_w_hs  = m_wvalid & m_wready;
    assign s_aw_hs = s_awvalid & s_awready;
    assign m_aw_hs = m_awvalid & m_awready;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0; stored <= '0; open_b <= '0; aocc <= '0;
        end else begin
            occ    <= occ + OW'(s_w_hs) - OW'(m_w_hs);
            stored <= stored + OW'(s_w_hs & s_wlast) - OW'(m_aw_hs);
            open_b <= open_b + OW'(m_aw_hs) - OW'(m_w_hs & m_wlast);
            aocc   <= aocc + AOW'(s_aw_hs) - AOW'(m_aw_hs);
        end
    end

    a_r4_addr_waits_for_burst: assert property (@(posedge clk) disable iff (rst)
        (MODE == WPF_PACKET && m_awvalid) |-> (stored != '0));

    a_r5_data_waits_for_addr: assert property (@(posedge clk) disable iff (rst)
        (MODE == WPF_PACKET && m_wvalid) |-> (open_b != '0));

    a_r6_no_midburst_gap: assert property (@(posedge clk) disable iff (rst)
        (MODE == WPF_PACKET && m_wvalid && m_wready && !m_wlast) |=> m_wvalid);

    a_r6_w_hold: assert property (@(posedge clk) disable iff (rst)
        (MODE != WPF_WIRE && m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    a_r4_aw_hold: assert property (@(posedge clk) disable iff (rst)
        (MODE == WPF_PACKET && m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    a_r7_w_room: assert property (@(posedge clk) disable iff (rst)
        (MODE != WPF_WIRE) |-> (s_wready == (occ < OW'(D_EFF))));

    a_r7_aw_room: assert property (@(posedge clk) disable iff (rst)
        (MODE == WPF_PACKET) |-> (s_awready == (aocc < AOW'(A_DEPTH))));

    a_r10_len_fits: assert property (@(posedge clk) disable iff (rst)
        (MODE == WPF_PACKET && s_awvalid && s_awready) |-> burst_fits(s_awlen, P_DEPTH));

    a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((MODE == WPF_WIRE || !m_wvalid) && (MODE != WPF_PACKET || !m_awvalid)));
endmodule

bind axi_wr_pkt_fifo axi_wr_pkt_fifo_chk #(
    .MODE(MODE), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .W_DEPTH(W_DEPTH), .P_DEPTH(P_DEPTH), .A_DEPTH(A_DEPTH)
) u_chk (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awlen(s_awlen),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wlast(s_wlast),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wlast(m_wlast),
    .m_wdata(m_wdata)
);

// File: tb/axi_wr_pkt_fifo_bench.sv
module axi_wr_pkt_fifo_bench;
    import axi_wpf_pkg::*;

    localparam int ADDR_W = 32, DATA_W = 32;
    localparam int WD = 4, PD = 8, AD = 4;

    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic              s_awvalid = 0, s_wvalid = 0, s_wlast = 0, s_bready = 0;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic [7:0]        s_awlen = '0;
    logic [2:0]        s_awsize = 3'd2;
    logic [1:0]        s_awburst = 2'b01;
    logic [DATA_W-1:0] s_wdata = '0;
    logic [3:0]        s_wstrb = 4'hF;
    logic              m_awready = 0, m_wready = 0, m_bvalid = 0;
    logic [1:0]        m_bresp = '0;

    logic p_s_awready, p_s_wready, p_s_bvalid, p_m_awvalid, p_m_wvalid, p_m_wlast, p_m_bready;
    logic q_s_awready, q_s_wready, q_s_bvalid, q_m_awvalid, q_m_wvalid, q_m_wlast, q_m_bready;
    logic z_s_awready, z_s_wready, z_s_bvalid, z_m_awvalid, z_m_wvalid, z_m_wlast, z_m_bready;
    logic [1:0] p_s_bresp, q_s_bresp, z_s_bresp, p_m_awburst, q_m_awburst, z_m_awburst;
    logic [2:0] p_m_awsize, q_m_awsize, z_m_awsize;
    logic [7:0] p_m_awlen, q_m_awlen, z_m_awlen;
    logic [3:0] p_m_wstrb, q_m_wstrb, z_m_wstrb;
    logic [ADDR_W-1:0] p_m_awaddr, q_m_awaddr, z_m_awaddr;
    logic [DATA_W-1:0] p_m_wdata, q_m_wdata, z_m_wdata;

    axi_wr_pkt_fifo #(.MODE(WPF_PACKET), .W_DEPTH(WD), .P_DEPTH(PD), .A_DEPTH(AD)) u_axi_wr_pkt_fifo (.*,
        .s_awready(p_s_awready), .s_wready(p_s_wready), .s_bvalid(p_s_bvalid), .s_bresp(p_s_bresp),
        .m_awvalid(p_m_awvalid), .m_awaddr(p_m_awaddr), .m_awlen(p_m_awlen), .m_awsize(p_m_awsize),
        .m_awburst(p_m_awburst), .m_wvalid(p_m_wvalid), .m_wdata(p_m_wdata), .m_wstrb(p_m_wstrb),
        .m_wlast(p_m_wlast), .m_bready(p_m_bready));

    axi_wr_pkt_fifo #(.MODE(WPF_DFIFO), .W_DEPTH(WD), .P_DEPTH(PD), .A_DEPTH(AD)) u_axi_wr_pkt_fifo_m1 (.*,
        .s_awready(q_s_awready), .s_wready(q_s_wready), .s_bvalid(q_s_bvalid), .s_bresp(q_s_bresp),
        .m_awvalid(q_m_awvalid), .m_awaddr(q_m_awaddr), .m_awlen(q_m_awlen), .m_awsize(q_m_awsize),
        .m_awburst(q_m_awburst), .m_wvalid(q_m_wvalid), .m_wdata(q_m_wdata), .m_wstrb(q_m_wstrb),
        .m_wlast(q_m_wlast), .m_bready(q_m_bready));

    axi_wr_pkt_fifo #(.MODE(WPF_WIRE), .W_DEPTH(WD), .P_DEPTH(PD), .A_DEPTH(AD)) u_axi_wr_pkt_fifo_m0 (.*,
        .s_awready(z_s_awready), .s_wready(z_s_wready), .s_bvalid(z_s_bvalid), .s_bresp(z_s_bresp),
        .m_awvalid(z_m_awvalid), .m_awaddr(z_m_awaddr), .m_awlen(z_m_awlen), .m_awsize(z_m_awsize),
        .m_awburst(z_m_awburst), .m_wvalid(z_m_wvalid), .m_wdata(z_m_wdata), .m_wstrb(z_m_wstrb),
        .m_wlast(z_m_wlast), .m_bready(z_m_bready));

    int n_chk = 0, n_bad = 0;
    logic [DATA_W-1:0] got_d[$];
    logic              got_l[$];
    logic [ADDR_W-1:0] got_a[$];
    logic [7:0]        got_n[$];
    logic              in_burst = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor of the packet copy: samples handshakes that complete at the next edge
    always @(negedge clk) begin
        if (rst) in_burst = 0;
        else begin
            if (in_burst) chk("R6 no gap inside burst", 64'(p_m_wvalid), 64'd1);
            if (p_m_wvalid && m_wready) begin
                got_d.push_back(p_m_wdata);
                got_l.push_back(p_m_wlast);
                in_burst = !p_m_wlast;
            end
            if (p_m_awvalid && m_awready) begin
                got_a.push_back(p_m_awaddr);
                got_n.push_back(p_m_awlen);
            end
        end
    end

    task automatic go_edge();
        @(posedge clk); #1;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) go_edge();
    endtask

    task automatic send_aw(input logic [ADDR_W-1:0] a, input logic [7:0] len);
        s_awvalid = 1; s_awaddr = a; s_awlen = len;
        do @(negedge clk); while (!p_s_awready);
        go_edge();
        s_awvalid = 0;
    endtask

    task automatic send_w(input logic [DATA_W-1:0] d, input logic last, input bit use_q);
        s_wvalid = 1; s_wdata = d; s_wlast = last; s_wstrb = d[3:0];
        do @(negedge clk); while (!(use_q ? q_s_wready : p_s_wready));
        go_edge();
        s_wvalid = 0; s_wlast = 0;
    endtask

    task automatic do_reset();
        rst = 1; wait_cycles(2); rst = 0; go_edge();
        got_d.delete(); got_l.delete(); got_a.delete(); got_n.delete();
    endtask

    task automatic t_wire_and_b();
        // done while reset is held: only combinational paths are observed
        s_awvalid = 1; s_awaddr = 32'hA5A5_0000; s_awlen = 8'd3; m_awready = 0; #1;
        chk("R1 awvalid copy", 64'(z_m_awvalid), 64'd1);
        chk("R1 awaddr copy", 64'(z_m_awaddr), 64'hA5A5_0000);
        chk("R1 awready low", 64'(z_s_awready), 64'd0);
        m_awready = 1; #1;
        chk("R1 awready high", 64'(z_s_awready), 64'd1);
        s_wvalid = 1; s_wdata = 32'h1234_5678; s_wlast = 1; m_wready = 0; #1;
        chk("R1 w copy", {z_m_wvalid, z_m_wlast, z_m_wdata}, {2'b11, 32'h1234_5678});
        chk("R1 wready low", 64'(z_s_wready), 64'd0);
        m_bvalid = 1; m_bresp = 2'd2; s_bready = 1; #1;
        chk("R8 bvalid mode2", 64'(p_s_bvalid), 64'd1);
        chk("R8 bresp mode1", 64'(q_s_bresp), 64'd2);
        chk("R8 bready mode0", 64'(z_m_bready), 64'd1);
        m_bvalid = 0; s_bready = 0; #1;
        chk("R8 b low again", {p_s_bvalid, q_s_bvalid, p_m_bready}, 3'b000);
        s_awvalid = 0; s_wvalid = 0; s_wlast = 0; m_awready = 0; m_wready = 0; s_awlen = 0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R9 packet valids low", {p_m_awvalid, p_m_wvalid}, 2'b00);
        chk("R9 dfifo wvalid low", 64'(q_m_wvalid), 64'd0);
        chk("R9 readies high", {p_s_awready, p_s_wready, q_s_wready}, 3'b111);
        go_edge();
    endtask

    task automatic t_dfifo();
        m_wready = 0;
        s_wvalid = 1; s_wdata = 32'hD0; s_wlast = 0; s_wstrb = 4'h0;
        @(negedge clk);
        chk("R2 nothing before handshake", 64'(q_m_wvalid), 64'd0);
        go_edge(); s_wvalid = 0;
        @(negedge clk);
        chk("R2 beat one cycle later", {q_m_wvalid, q_m_wdata}, {1'b1, 32'hD0});
        go_edge();
        for (int i = 1; i < WD; i++) send_w(32'hD0 + i, i == WD - 1, 1'b1);
        @(negedge clk);
        chk("R2 wready low when full", 64'(q_s_wready), 64'd0);
        s_awvalid = 1; m_awready = 1; #1;
        chk("R2 aw wired through", {q_m_awvalid, q_s_awready}, 2'b11);
        s_awvalid = 0; m_awready = 0;
        go_edge();
        m_wready = 1;
        for (int i = 0; i < WD; i++) begin
            @(negedge clk);
            chk("R3 dfifo beat order", {q_m_wvalid, q_m_wlast, q_m_wstrb, q_m_wdata},
                {1'b1, 1'(i == WD - 1), 4'(32'hD0 + i), 32'hD0 + i});
            go_edge();
        end
        m_wready = 0;
    endtask

    task automatic t_release_gate();
        m_awready = 0; m_wready = 1;
        send_aw(32'h100, 8'd3);
        for (int i = 0; i < 3; i++) send_w(32'hB0 + i, 1'b0, 1'b0);
        @(negedge clk);
        chk("R4 no address before last beat", 64'(p_m_awvalid), 64'd0);
        chk("R5 no data before address", 64'(p_m_wvalid), 64'd0);
        go_edge();
        send_w(32'hB3, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4 address after last beat", 64'(p_m_awvalid), 64'd1);
        chk("R5 data still held", 64'(p_m_wvalid), 64'd0);
        go_edge();
        m_awready = 1; go_edge(); m_awready = 0;
        wait_cycles(8);
        chk("R3 one address out", 64'(got_a.size()), 64'd1);
        if (got_a.size() == 1) chk("R3 address value", 64'(got_a[0]), 64'h100);
        chk("R3 four beats out", 64'(got_d.size()), 64'd4);
        for (int i = 0; i < 4 && i < got_d.size(); i++)
            chk("R3 packet beat", {got_l[i], got_d[i]}, {1'(i == 3), 32'hB0 + i});
        got_d.delete(); got_l.delete(); got_a.delete(); got_n.delete();
    endtask

    task automatic t_data_first();
        m_awready = 1; m_wready = 1;
        send_w(32'hE0, 1'b0, 1'b0);
        send_w(32'hE1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R5 data waits without address", 64'(p_m_wvalid), 64'd0);
        chk("R4 no address offered", 64'(p_m_awvalid), 64'd0);
        go_edge();
        send_aw(32'h200, 8'd1);
        send_aw(32'h300, 8'd2);
        for (int i = 0; i < 3; i++) send_w(32'hF0 + i, i == 2, 1'b0);
        wait_cycles(10);
        chk("R3 two addresses", 64'(got_a.size()), 64'd2);
        if (got_a.size() == 2)
            chk("R3 address order", {got_a[0], got_n[0], got_a[1], got_n[1]},
                {32'h200, 8'd1, 32'h300, 8'd2});
        chk("R3 five beats", 64'(got_d.size()), 64'd5);
        if (got_d.size() == 5)
            chk("R3 beat order", {got_d[0], got_d[1], got_d[2], got_d[4], got_l[1], got_l[4]},
                {32'hE0, 32'hE1, 32'hF0, 32'hF2, 2'b11});
        got_d.delete(); got_l.delete(); got_a.delete(); got_n.delete();
    endtask

    task automatic t_full();
        m_awready = 0; m_wready = 0;
        send_aw(32'h400, 8'(PD - 1));
        for (int i = 0; i < PD; i++) send_w(32'hC0 + i, i == PD - 1, 1'b0);
        @(negedge clk);
        chk("R7 wready low when data full", 64'(p_s_wready), 64'd0);
        chk("R10 full-depth burst released", 64'(p_m_awvalid), 64'd1);
        go_edge();
        for (int i = 1; i < AD; i++) send_aw(32'h400 + 32'(i) * 32'h100, 8'd0);
        @(negedge clk);
        chk("R7 awready low when address full", 64'(p_s_awready), 64'd0);
        go_edge();
        m_awready = 1; m_wready = 1;
        wait_cycles(PD + 4);
        chk("R10 all beats of full burst", 64'(got_d.size()), 64'(PD));
        for (int i = 0; i < PD && i < got_d.size(); i++)
            chk("R10 full burst data", 64'(got_d[i]), 64'(32'hC0 + i));
        for (int i = 0; i < AD - 1; i++) send_w(32'h90 + i, 1'b1, 1'b0);
        wait_cycles(8);
        chk("R3 all addresses drained", 64'(got_a.size()), 64'(AD));
        chk("R3 all beats drained", 64'(got_d.size()), 64'(PD + AD - 1));
        if (got_d.size() == PD + AD - 1)
            chk("R3 single-beat tail", {got_d[PD], got_d[PD+AD-2]}, {32'h90, 32'h90 + AD - 2});
        m_awready = 0; m_wready = 0;
    endtask

    initial begin
        rst = 1;
        wait_cycles(2);
        t_wire_and_b();
        rst = 0; go_edge();
        t_reset_state();
        t_dfifo();
        do_reset();
        t_release_gate();
        t_data_first();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule